// File: doc/BRIEF.md
# Marker-Based Byte Boundary Aligner

This block follows an 8-bit deserializer. After skew correction the deserializer delivers one word per clock, but the word boundary can fall anywhere inside the serial stream. A single-cycle align command starts a search for the fixed marker byte 0xA1 (binary 10100001). The block keeps the word from the previous cycle next to the word arriving now, which gives a 16-bit window. Each cycle it compares every 8-bit slice of that window with the marker.

When a slice matches, the block locks that bit offset and raises its done flag. From then on it rebuilds every received word from the same slice, so the output carries the original byte stream. Downstream logic starts taking user data on the rising edge of done. A new align command can be issued at any time and discards the current lock. A reset also discards it.

Top module: `marker_aligner`

## Requirements
- R1: Reset (rst_n low) clears the lock, the search and the output. After reset, done is 0 and dout is 0x00. Until an align pulse arrives, a marker in the input stream has no effect and done stays 0.
- R2: In the cycle after align_req is sampled high, done is 0. It stays 0 until a marker match occurs.
- R3: While searching, the window is {previous din, current din}, with the previous word in bits 15:8. Slice k is window[k+7:k], for k = 0 to 7. Every slice is compared with 0xA1 on every cycle. Without a match the search never ends, and done stays 0 for as long as that lasts.
- R4: In the cycle in which done rises, dout is 0xA1, the matched marker itself.
- R5: Once locked, each later output word is slice k of the window one clock earlier. So the bytes that follow the marker appear on dout in order, one per cycle.
- R6: The block aligns a stream delayed by s bits, for every s from 0 to 7. In such a stream each input word holds the last s bits of one byte above the first 8-s bits of the next byte. The case s = 4 is included.
- R7: When more than one slice matches in the same cycle, the lowest k wins. For example, window 0x50A1 matches at k=0 and at k=7, and the block locks k=0.
- R8: dout is 0x00 in every cycle in which done is 0.
- R9: An align pulse while locked drops done and restarts the search. The block then locks onto the offset of the new stream.
- R10: While locked and with no align pulse, done stays 1 and the offset does not change. A marker at another offset in the data has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one deserialized word per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| align_req | input | 1 | One-cycle pulse that starts or restarts the marker search |
| din | input | 8 | Parallel word from the deserializer, boundary unknown |
| dout | output | 8 | Word rebuilt on the locked boundary; zero while not locked |
| done | output | 1 | High while a boundary is locked |

## Verification
The checker watches several rules on every clock. Output is zero whenever done is low. The first word at a rising done is the marker. Done is low after every align pulse. While locked without a new pulse, done and the stored offset both hold.

Other behaviours only the bench's scenarios can show:
- the right offset being found for each of the eight delays;
- the payload bytes coming out in order after the marker;
- the lowest offset winning when two slices match together;
- an endless search on marker-free data;
- markers being ignored after reset and while locked;
- re-alignment to a differently delayed stream.

// File: rtl/marker_aligner.sv
module marker_aligner #(
  parameter int          DW     = 8,
  parameter logic [DW-1:0] MARKER = 8'hA1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          align_req,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          done
);
  localparam int OFFW = $clog2(DW);
  localparam int WINW = 2 * DW;

  logic [DW-1:0]   prev_q;
  logic [WINW-1:0] window;
  logic [DW-1:0]   slc [DW];
  logic [DW-1:0]   hit;
  logic [OFFW-1:0] hit_idx, off_q, off_n;
  logic            srch_q, srch_n, done_q, done_n;
  logic [DW-1:0]   dout_q;

  assign window = {prev_q, din};

  for (genvar k = 0; k < DW; k++) begin : g_slice
    assign slc[k] = window[k+DW-1:k];
    assign hit[k] = (slc[k] == MARKER);
  end

  always_comb begin
    hit_idx = '0;
    for (int k = DW - 1; k >= 0; k--)
      if (hit[k]) hit_idx = OFFW'(k);
  end

  always_comb begin
    srch_n = srch_q;
    done_n = done_q;
    off_n  = off_q;
    if (align_req) begin
      srch_n = 1'b1;
      done_n = 1'b0;
    end else if (srch_q && |hit) begin
      srch_n = 1'b0;
      done_n = 1'b1;
      off_n  = hit_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      srch_q <= 1'b0;
      done_q <= 1'b0;
      off_q  <= '0;
      dout_q <= '0;
    end else begin
      prev_q <= din;
      srch_q <= srch_n;
      done_q <= done_n;
      off_q  <= off_n;
      dout_q <= done_n ? slc[off_n] : '0;
    end
  end

  assign dout = dout_q;
  assign done = done_q;
endmodule

module marker_aligner_chk #(
  parameter int          DW     = 8,
  parameter logic [DW-1:0] MARKER = 8'hA1,
  parameter int          OFFW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            align_req,
  input logic            done,
  input logic [DW-1:0]   dout,
  input logic            srch_q,
  input logic [OFFW-1:0] off_q
);
  // R8
  zero_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> dout == '0);
  // R4
  marker_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> dout == MARKER);
  // R2
  align_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_req |=> !done);
  // R10
  lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !align_req) |=> (done && $stable(off_q)));
  // R3
  rise_needs_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(srch_q));
  // R1
  idle_no_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!srch_q && !done && !align_req) |=> !done);
endmodule

bind marker_aligner marker_aligner_chk #(.DW(DW), .MARKER(MARKER), .OFFW(OFFW)) u_chk (
  .clk(clk), .rst_n(rst_n), .align_req(align_req), .done(done),
  .dout(dout), .srch_q(srch_q), .off_q(off_q)
);

// File: tb/marker_aligner_test.sv
module marker_aligner_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       align_req = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       done;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  marker_aligner uut (.clk(clk), .rst_n(rst_n), .align_req(align_req),
                      .din(din), .dout(dout), .done(done));

  // {shift, payload seed}
  localparam logic [10:0] VEC [6] = '{
    {3'd0, 8'h10}, {3'd4, 8'h2B}, {3'd1, 8'h77},
    {3'd7, 8'h05}, {3'd3, 8'h9E}, {3'd5, 8'h41}
  };

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] d, input logic a);
    din = d;
    align_req = a;
    @(posedge clk);
    @(negedge clk);
    align_req = 1'b0;
  endtask

  function automatic logic [7:0] tx(input logic [7:0] a, input logic [7:0] b, input int s);
    logic [15:0] t;
    t = {a, b} >> s;
    return t[7:0];
  endfunction

  task automatic align_pulse();
    step(8'h00, 1'b1);
    chk(done == 1'b0, "R2 done low after align", {7'd0, done}, 8'h00);
    chk(dout == 8'h00, "R8 dout zero after align", dout, 8'h00);
  endtask

  task automatic feed_stream(input int s, input logic [7:0] seed, input string req);
    logic [7:0] u [14];
    logic [7:0] pv;
    bit seen;
    int idx;
    for (int i = 0; i < 14; i++) u[i] = 8'h00;
    u[3] = 8'hA1;
    for (int i = 0; i < 6; i++) u[4+i] = seed + 8'(i * 29);
    u[4] = u[4] | 8'hC0;
    pv = 8'h00;
    seen = 0;
    idx = 0;
    for (int n = 0; n < 14; n++) begin
      step(tx(pv, u[n], s), 1'b0);
      pv = u[n];
      if (done && !seen) begin
        seen = 1;
        chk(dout == 8'hA1, "R4 marker on done rise", dout, 8'hA1);
      end else if (seen && idx < 6) begin
        chk(dout == u[4+idx], req, dout, u[4+idx]);
        idx++;
      end else if (!seen) begin
        chk(dout == 8'h00, "R8 zero while searching", dout, 8'h00);
      end
    end
    chk(seen && idx == 6, "R6 alignment completed", 8'(idx), 8'd6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 8'h01, 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(done == 1'b0 && dout == 8'h00, "R1 reset state", dout, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: marker without an align pulse is ignored
    step(8'h00, 1'b0);
    for (int i = 0; i < 4; i++) begin
      step(8'hA1, 1'b0);
      chk(done == 1'b0 && dout == 8'h00, "R1 marker ignored before align", dout, 8'h00);
    end

    // table of shifts: R3 R4 R5 R6
    for (int v = 0; v < 6; v++) begin
      step(8'h00, 1'b0);
      align_pulse();
      feed_stream(int'(VEC[v][10:8]), VEC[v][7:0], "R5 payload order");
    end

    // R3: search lasts indefinitely without a marker
    align_pulse();
    for (int i = 0; i < 30; i++) begin
      step(8'h00, 1'b0);
      chk(done == 1'b0, "R3 still searching", {7'd0, done}, 8'h00);
    end
    feed_stream(6, 8'h33, "R3 late marker payload");

    // lock at shift 4, then R10: other-offset markers ignored
    align_pulse();
    feed_stream(4, 8'h5A, "R6 shift 4 payload");
    begin
      logic [7:0] pv;
      logic [7:0] w;
      logic [15:0] t;
      pv = 8'h00;
      for (int i = 0; i < 6; i++) begin
        w = (i == 2) ? 8'hA1 : ((i == 3) ? 8'h28 : 8'h6D + 8'(i));
        step(w, 1'b0);
        t = {pv, w} >> 4;
        chk(done == 1'b1 && dout == t[7:0], "R10 lock held", dout, t[7:0]);
        pv = w;
      end
    end

    // R9: realign during operation to a new shift
    align_pulse();
    feed_stream(2, 8'hE4, "R9 realigned payload");

    // R7: two slices match, lowest offset wins
    align_pulse();
    step(8'h00, 1'b0);
    step(8'h50, 1'b0);
    step(8'hA1, 1'b0);
    chk(done == 1'b1 && dout == 8'hA1, "R7 match on 0x50A1", dout, 8'hA1);
    step(8'h3C, 1'b0);
    chk(dout == 8'h3C, "R7 lowest offset chosen", dout, 8'h3C);

    // R1: reset during operation clears lock and search
    din = 8'h00;
    rst_n = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && dout == 8'h00, "R1 reset clears lock", dout, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    step(8'h00, 1'b0);
    step(8'hA1, 1'b0);
    step(8'hC5, 1'b0);
    chk(done == 1'b0 && dout == 8'h00, "R1 no search after reset", dout, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule